// File: doc/BRIEF.md
# Serial Angle Word Receiver

This block is a synchronous serial master that fetches one angle word from a position converter over a three-wire link. On a start request it pulls an active-low select line low, toggles a serial clock derived from the system clock, and samples the returned data line once per bit. Framing bits are discarded, and the 12 significant bits are placed in an output register that changes only when a frame completes. A one-cycle strobe marks the new word.

A static mode input describes how the converter frames its word. Three framings are supported: a long frame with one void leading bit and trailing padding, a frame with a single leading bit, and a plain frame in which every bit is significant. The mode also sets which serial clock edge samples the data. The serial clock half period is set in system clock cycles by a divider input. Mode and divider are captured when a frame is accepted, so they may change while a frame runs.

Top module: `serang_rx`

## Requirements
- R1: While reset is asserted, `cs_n` and `sclk` are 1, and `busy`, `angle_valid` and `angle` are all 0.
- R2: With `mode` = 2'b00 the frame is 16 bits long. The first bit is discarded, the next 12 form `angle`, and the last 3 are discarded, whatever their values.
- R3: With `mode` = 2'b01 the frame is 13 bits long. The first bit is discarded and the remaining 12 form `angle`.
- R4: With `mode` = 2'b10 or 2'b11 the frame is 12 bits long, all significant, and each bit is sampled at the rising `sclk` edge. In modes 2'b00 and 2'b01 each bit is sampled at the falling `sclk` edge.
- R5: The first significant bit received becomes `angle[11]` and the last becomes `angle[0]`.
- R6: `sclk` stays high whenever `cs_n` is high and toggles only while `cs_n` is low. `cs_n` stays low without a break from frame acceptance until every bit of the frame has been clocked.
- R7: Each frame produces exactly as many falling `sclk` edges as the mode's frame length (16, 13 or 12).
- R8: `angle_valid` is high for exactly one cycle, in the cycle `cs_n` returns high after a frame. `angle` changes only in that cycle.
- R9: `start` is accepted only while `busy` is low. A start pulse while `busy` is high neither restarts the frame nor causes an extra frame.
- R10: `busy` is high from the cycle after a start is accepted until at least two half periods after `cs_n` rises. Between frames `cs_n` stays high for at least two half periods.
- R11: Every `sclk` level lasts `div_half` system cycles, with 0 treated as 1. The time from the `cs_n` fall to the first `sclk` fall is also one half period.
- R12: `mode` and `div_half` are captured when a frame is accepted. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to read one angle word |
| mode | input | 2 | Framing mode: 00 void+12+pad, 01 lead+12, 10/11 plain 12 |
| div_half | input | DIV_W | Serial clock half period in system cycles (0 means 1) |
| sdata | input | 1 | Serial data from converter |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Converter select, active low |
| busy | output | 1 | Frame or inter-frame gap in progress |
| angle | output | DATA_W | Last received angle word |
| angle_valid | output | 1 | One-cycle strobe when `angle` is updated |

## Verification
Two things can fall in the same cycle: the completion of a frame, with its word strobe and the select release, and a pending start request. The bench holds `start` high for the whole of one frame, so the request is present in the cycle the word is delivered and throughout the gap. It checks that `cs_n` is high while the strobe is up, that the gap before the next select is at least two half periods, that the held request then starts exactly one further frame, and that the second word matches the second data pattern.

// File: rtl/serang_pkg.sv
package serang_pkg;

   typedef enum logic [1:0] {
      FRM_VOID_PAD = 2'b00,
      FRM_LEAD     = 2'b01,
      FRM_PLAIN    = 2'b10,
      FRM_PLAIN_B  = 2'b11
   } frame_mode_e;

   // number of bits clocked per frame for a payload of dw bits
   function automatic int unsigned frame_len(frame_mode_e m, int unsigned dw);
      case (m)
         FRM_VOID_PAD: frame_len = dw + 4;
         FRM_LEAD:     frame_len = dw + 1;
         default:      frame_len = dw;
      endcase
   endfunction

   // bits discarded ahead of the payload
   function automatic int unsigned lead_len(frame_mode_e m);
      case (m)
         FRM_VOID_PAD, FRM_LEAD: lead_len = 1;
         default:                lead_len = 0;
      endcase
   endfunction

   // 1: sample on the rising serial clock edge, 0: on the falling edge
   function automatic logic rise_sample(frame_mode_e m);
      rise_sample = (m == FRM_PLAIN) || (m == FRM_PLAIN_B);
   endfunction

endpackage

// File: rtl/serang_seq.sv
module serang_seq
   import serang_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  frame_mode_e       mode_i,
   input  logic [DIV_W-1:0]  div_half,
   output logic              sclk,
   output logic              cs_n,
   output logic              busy,
   output logic              frm_start,
   output logic              smp,
   output logic              fin,
   output frame_mode_e       mode_q
);

   localparam int MAX_BITS = DATA_W + 4;
   localparam int EW       = $clog2(2 * MAX_BITS + 1);
   localparam int TW       = DIV_W + 1;

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} seq_st_e;

   seq_st_e          st;
   logic [TW-1:0]    tmr;
   logic [EW-1:0]    ecnt;
   logic [DIV_W-1:0] half_q;
   logic [DIV_W-1:0] half_eff;
   logic [EW-1:0]    edges_total;
   logic             tick;

   assign half_eff    = (div_half == '0) ? DIV_W'(1) : div_half;
   assign edges_total = EW'(2 * frame_len(mode_q, DATA_W));
   assign tick        = (st == S_RUN) && (tmr == '0);

   assign busy      = (st != S_IDLE);
   assign frm_start = (st == S_IDLE) && start;
   assign fin       = tick && (ecnt == edges_total);
   // sample at the edge about to be produced when its direction matches the mode
   assign smp       = tick && (ecnt != edges_total) && ((~sclk) == rise_sample(mode_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         tmr    <= '0;
         ecnt   <= '0;
         half_q <= DIV_W'(1);
         mode_q <= FRM_VOID_PAD;
         sclk   <= 1'b1;
         cs_n   <= 1'b1;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  cs_n   <= 1'b0;
                  half_q <= half_eff;
                  mode_q <= mode_i;
                  ecnt   <= '0;
                  tmr    <= TW'(half_eff) - TW'(1);
                  st     <= S_RUN;
               end
            end
            S_RUN: begin
               if (tmr != '0) begin
                  tmr <= tmr - TW'(1);
               end else if (ecnt == edges_total) begin
                  cs_n <= 1'b1;
                  tmr  <= (TW'(half_q) << 1) - TW'(1);
                  st   <= S_GAP;
               end else begin
                  sclk <= ~sclk;
                  ecnt <= ecnt + EW'(1);
                  tmr  <= TW'(half_q) - TW'(1);
               end
            end
            S_GAP: begin
               if (tmr == '0) st <= S_IDLE;
               else           tmr <= tmr - TW'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R6: the serial clock moves only while the converter is selected
   a_r6_sclk_moves_selected: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> !cs_n);

   // R6: deselected link idles with the clock high
   a_r6_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk);

   // R10: releasing select is followed by a gap during which busy stays high
   a_r10_gap_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> busy);

endmodule

// File: rtl/serang_capture.sv
module serang_capture
   import serang_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frm_start,
   input  logic              smp,
   input  logic              fin,
   input  logic              sdata,
   input  frame_mode_e       mode_q,
   output logic [DATA_W-1:0] angle,
   output logic              angle_valid
);

   localparam int BW = $clog2(DATA_W + 5);

   logic [BW-1:0]     bcnt;
   logic [DATA_W-1:0] shreg;
   logic [BW-1:0]     lead_v;
   logic              in_payload;

   assign lead_v     = BW'(lead_len(mode_q));
   assign in_payload = (bcnt >= lead_v) && (bcnt < lead_v + BW'(DATA_W));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt  <= '0;
         shreg <= '0;
      end else if (frm_start) begin
         bcnt  <= '0;
         shreg <= '0;
      end else if (smp) begin
         bcnt <= bcnt + BW'(1);
         if (in_payload) shreg <= {shreg[DATA_W-2:0], sdata};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         angle       <= '0;
         angle_valid <= 1'b0;
      end else begin
         angle_valid <= fin;
         if (fin) angle <= shreg;
      end
   end

   // R7: by frame end the sampler has taken exactly the frame length in bits
   a_r7_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (bcnt == BW'(frame_len(mode_q, DATA_W))));

endmodule

// File: rtl/serang_rx.sv
module serang_rx
   import serang_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic [DIV_W-1:0]  div_half,
   input  logic              sdata,
   output logic              sclk,
   output logic              cs_n,
   output logic              busy,
   output logic [DATA_W-1:0] angle,
   output logic              angle_valid
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("serang_rx: DATA_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("serang_rx: DIV_W must be at least 1");
      end
   endgenerate

   logic        frm_start;
   logic        smp;
   logic        fin;
   frame_mode_e mode_q;

   serang_seq #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode_i    (frame_mode_e'(mode)),
      .div_half  (div_half),
      .sclk      (sclk),
      .cs_n      (cs_n),
      .busy      (busy),
      .frm_start (frm_start),
      .smp       (smp),
      .fin       (fin),
      .mode_q    (mode_q)
   );

   serang_capture #(.DATA_W(DATA_W)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .frm_start   (frm_start),
      .smp         (smp),
      .fin         (fin),
      .sdata       (sdata),
      .mode_q      (mode_q),
      .angle       (angle),
      .angle_valid (angle_valid)
   );

   // R8: the word strobe never lasts two cycles
   a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      angle_valid |=> !angle_valid);

   // R8: the output word changes only together with the strobe
   a_r8_angle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !angle_valid |-> $stable(angle));

   // R8: the strobe coincides with select being released
   a_r8_valid_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      angle_valid |-> (cs_n && $past(!cs_n)));

   // R9: a frame can begin only from the idle condition
   a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> $past(!busy));

   // R6: select low implies a frame in progress
   a_r6_select_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy);

endmodule

// File: tb/tb_serang_rx.sv
`timescale 1ns/1ps
module tb_serang_rx;

   localparam int DATA_W = 12;
   localparam int DIV_W  = 8;

   typedef struct {
      logic [1:0]  mode;
      int          h;
      logic [11:0] ang;
      int          nbits;
      string       tag;
   } exp_t;

   typedef struct {
      logic [1:0]  mode;
      logic [15:0] fr;
   } frm_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [1:0]        mode_r = 2'b00;
   logic [DIV_W-1:0]  div_r = 8'd1;
   logic              sdata = 1'b1;
   logic              sclk, cs_n, busy, angle_valid;
   logic [DATA_W-1:0] angle;

   int checks = 0;
   int failures = 0;

   exp_t eq[$];
   frm_t mq[$];

   always #4 clk = ~clk;

   serang_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_r),
      .div_half(div_r), .sdata(sdata), .sclk(sclk), .cs_n(cs_n),
      .busy(busy), .angle(angle), .angle_valid(angle_valid)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int nbits_of(input logic [1:0] m);
      case (m)
         2'b00:   return 16;
         2'b01:   return 13;
         default: return 12;
      endcase
   endfunction

   // non-payload positions are driven to 1 so that leaking them shows up
   function automatic logic [15:0] mk_frame(input logic [1:0] m, input logic [11:0] a);
      case (m)
         2'b00, 2'b01: return {1'b1, a, 3'b111};
         default:      return {a, 4'b1111};
      endcase
   endfunction

   // converter model: presents the next bit after each of the master's sampling edges
   logic m_prev_cs = 1'b1, m_prev_sclk = 1'b1;
   frm_t cur_fr;
   int   idx = 0;
   always @(negedge clk) begin
      if (cs_n) begin
         idx   = 0;
         sdata = 1'b1;
      end else begin
         if (m_prev_cs) begin
            if (mq.size() > 0) cur_fr = mq.pop_front();
            idx = 0;
         end else if (sclk != m_prev_sclk && sclk == (cur_fr.mode[1] ? 1'b1 : 1'b0)) begin
            idx++;
         end
         sdata = (idx < 16) ? cur_fr.fr[15 - idx] : 1'b1;
      end
      m_prev_cs   = cs_n;
      m_prev_sclk = sclk;
   end

   // monitor / scoreboard
   logic        p_sclk = 1'b1, p_cs = 1'b1, p_valid = 1'b0;
   logic [11:0] p_angle = '0;
   int cnt = 0, falls = 0, hi_cnt = 0, last_h = 1;
   bit had = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sclk !== p_sclk) begin
            if (cs_n) chk(0, "R6", "sclk moved while deselected", sclk, p_sclk);
            else if (eq.size() > 0) chk(cnt == eq[0].h, "R11", "half period", cnt, eq[0].h);
            if (!sclk) falls++;
            cnt = 1;
         end else if (cs_n !== p_cs) begin
            if (!cs_n) begin
               if (eq.size() > 0) chk(sclk == 1'b1, "R6", "sclk at select", sclk, 1);
               if (had) chk(hi_cnt >= 2 * last_h, "R10", "deselect gap", hi_cnt, 2 * last_h);
               falls  = 0;
               hi_cnt = 0;
            end
            cnt = 1;
         end else begin
            cnt++;
         end
         if (cs_n) hi_cnt++;
         if (!cs_n && !busy) chk(0, "R10", "busy low during frame", busy, 1);
         if (angle_valid) begin
            if (p_valid) chk(0, "R8", "strobe longer than one cycle", 1, 0);
            chk(cs_n == 1'b1, "R8", "select at strobe", cs_n, 1);
            if (eq.size() == 0) begin
               chk(0, "R9", "unexpected word", angle, 0);
            end else begin
               exp_t e;
               e = eq.pop_front();
               chk(angle == e.ang, e.tag, "angle word", angle, e.ang);
               chk(falls == e.nbits, "R7", "falling edges per frame", falls, e.nbits);
               last_h = e.h;
               had    = 1;
            end
         end else if (angle !== p_angle) begin
            chk(0, "R8", "angle changed without strobe", angle, p_angle);
         end
      end
      p_sclk  = sclk;
      p_cs    = cs_n;
      p_valid = angle_valid;
      p_angle = angle;
   end

   task automatic push_exp(input logic [1:0] m, input int dv, input logic [11:0] a,
                           input string tag);
      exp_t e;
      frm_t f;
      e.mode = m; e.h = (dv == 0) ? 1 : dv; e.ang = a; e.nbits = nbits_of(m); e.tag = tag;
      f.mode = m; f.fr = mk_frame(m, a);
      eq.push_back(e);
      mq.push_back(f);
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   task automatic run_frame(input logic [1:0] m, input int dv, input logic [11:0] a,
                            input string tag, input bit stray);
      wait_idle();
      mode_r = m;
      div_r  = DIV_W'(dv);
      push_exp(m, dv, a, tag);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (stray) begin
         // R9 / R12: request and settings change while the frame runs
         repeat (6) @(negedge clk);
         mode_r = 2'b10;
         div_r  = 8'd5;
         start  = 1'b1;
         @(negedge clk);
         start  = 1'b0;
      end
      wait_idle();
   endtask

   // start held high across frame end: coincides with the strobe and the gap
   task automatic run_held(input logic [1:0] m, input int dv,
                           input logic [11:0] a1, input logic [11:0] a2);
      wait_idle();
      mode_r = m;
      div_r  = DIV_W'(dv);
      push_exp(m, dv, a1, "R10");
      push_exp(m, dv, a2, "R10");
      start = 1'b1;
      do @(negedge clk); while (!angle_valid);
      while (cs_n) @(negedge clk);
      start = 1'b0;
      wait_idle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
      chk(sclk == 1'b1, "R1", "sclk in reset", sclk, 1);
      chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
      chk(angle_valid == 1'b0, "R1", "valid in reset", angle_valid, 0);
      chk(angle == '0, "R1", "angle in reset", angle, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_frame(2'b00, 1, 12'hA5C, "R2", 0);
      run_frame(2'b00, 2, 12'h000, "R2", 0);
      run_frame(2'b01, 1, 12'h3F1, "R3", 0);
      run_frame(2'b01, 3, 12'h000, "R3", 0);
      run_frame(2'b10, 3, 12'h5A5, "R4", 0);
      run_frame(2'b11, 2, 12'h2C6, "R4", 0);
      run_frame(2'b10, 1, 12'h801, "R5", 0);
      run_frame(2'b00, 1, 12'h400, "R5", 0);
      run_frame(2'b01, 0, 12'h123, "R11", 0);
      run_frame(2'b00, 2, 12'h7E4, "R12", 1);
      run_held(2'b01, 1, 12'h456, 12'hBA9);
      run_held(2'b10, 2, 12'hFFF, 12'h001);

      repeat (4) @(negedge clk);
      chk(eq.size() == 0, "R9", "words outstanding", eq.size(), 0);
      chk(mq.size() == 0, "R9", "frames outstanding", mq.size(), 0);
      chk(busy == 1'b0 && cs_n == 1'b1, "R9", "idle at end", {busy, cs_n}, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule